// File: doc/BRIEF.md
# Card-Host Single-Segment DMA Engine

This block moves data between the data FIFO of an SD/SDIO card host and system memory, one contiguous segment per transfer. Software picks a direction through a mode register: the memory-to-card channel (channel 0) feeds card writes, and the card-to-memory channel (channel 1) collects card reads. Software also sets a 128-byte-aligned start address and a beat count, then writes a start bit. The engine moves one 64-bit word per beat. It raises a per-channel end flag when the segment is finished, or a per-channel error flag when the start address is misaligned.

Registers are 64 bits wide and sit at fixed offsets inside a 12-bit window. Writes go through a one-cycle write port and reads through a combinational read port. Each channel has an active-low reset bit that aborts its transfer and keeps the channel idle. Two mask registers gate the end flags and the error flags onto a single interrupt line. The memory side is a request/acknowledge word port. The card side has two valid/ready FIFO handshakes, one per direction.

Top module: `sdcard_dma`

## Requirements
- R1: After reset, every register reads back as follows:
  - mode, control, status, error and address read zero;
  - both mask registers read 0x0000_0000_FFFF_FFFF;
  - the channel-reset register reads 0x0000_0000_FFFF_FFFF.

  After reset `irq`, `mem_req`, `tx_valid` and `rx_ready` are low.
- R2: The mode register (offset 0x820) keeps bit 16 (channel), bits 5:4 (bus width) and bit 0 (increment), and reads zero elsewhere. With bit 16 clear, each beat reads one memory word and presents it on `tx_data`. Beats follow address order, and one word is presented per beat.
- R3: With mode bit 16 set, each word accepted from `rx_data` is written to memory (`mem_we` high) in arrival order. `mem_we` equals the active channel whenever `mem_req` is high.
- R4: With mode bit 0 set, beat k uses address base + 8·k. With mode bit 0 clear, every beat uses the base address held in the address register (0x880).
- R5: Writing 1 to bit 0 of the control register (0x828) starts a transfer only when the engine is idle. A start or a mode write during a transfer does not change that transfer. The control register reads as zero. No memory or FIFO handshake is driven while the engine is idle.
- R6: A start whose address has any of bits 6:0 set moves no data. It sets the error flag of the selected channel (error register 0x850, bit 16 + channel) in the cycle after the start write, and the engine stays idle.
- R7: The end flag of a channel (end register 0x840, bit 16 + channel) sets one cycle after the destination accepts the last beat.
- R8: A write to the end register or the error register clears every flag whose bit in the written word is 0 and keeps the others. Writing 0 therefore clears all flags.
- R9: `irq` is high exactly when some end or error flag is set and its bit in the mask register is 0. The end mask is at 0x848 and the error mask at 0x858, bits 17:16. A mask bit of 1 hides the matching flag.
- R10: The channel-reset register (0x830) holds bit 8 for channel 0 and bit 9 for channel 1, both active low.
  - With its bit low, a channel's running transfer stops within one cycle with no end flag, its flags stay clear, and starts for it are ignored.
  - The other channel keeps working normally.
  - Bits 31:0 of this register always read as ones.
- R11: A start with a beat count of zero moves no data and sets the end flag two cycles after the start write.
- R12: Once `mem_req` is raised, it stays high with unchanged address, direction and write data until `mem_ack` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | 12 | Register write offset |
| cfg_wdata | input | 64 | Register write data |
| cfg_raddr | input | 12 | Register read offset |
| cfg_rdata | output | 64 | Register read data (combinational) |
| xfer_count | input | CW (32) | Beat count from the card host, sampled at start |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 64 | Memory word address |
| mem_wdata | output | DW (64) | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, ends the request |
| mem_rdata | input | DW (64) | Memory read data, valid with `mem_ack` |
| tx_valid | output | 1 | Word for the card FIFO is valid |
| tx_ready | input | 1 | Card FIFO accepts the word |
| tx_data | output | DW (64) | Word to the card FIFO |
| rx_valid | input | 1 | Word from the card FIFO is valid |
| rx_ready | output | 1 | Engine accepts a word from the card FIFO |
| rx_data | input | DW (64) | Word from the card FIFO |
| irq | output | 1 | OR of all unmasked end and error flags |

## Verification
The bound assertions check the following on every cycle:
- memory requests are held until acknowledged;
- only one handshake is active at a time;
- the direction follows the active channel;
- an idle engine drives nothing;
- a misaligned start leaves the engine idle and flags an error;
- every finished transfer leaves its end flag set;
- a channel reset empties the engine;
- all-ones masks silence `irq`.

The bench's scenarios cover what the assertions cannot see:
- the order and values of data words;
- the increment and fixed address patterns;
- the exact cycle in which an end flag appears;
- partial flag clearing;
- that ignored starts and mode writes leave a running transfer intact.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  localparam int REG_AW = 12;

  // register window offsets
  localparam logic [REG_AW-1:0] OFF_MODE     = 12'h820;
  localparam logic [REG_AW-1:0] OFF_CTRL     = 12'h828;
  localparam logic [REG_AW-1:0] OFF_RST      = 12'h830;
  localparam logic [REG_AW-1:0] OFF_END      = 12'h840;
  localparam logic [REG_AW-1:0] OFF_END_MASK = 12'h848;
  localparam logic [REG_AW-1:0] OFF_ERR      = 12'h850;
  localparam logic [REG_AW-1:0] OFF_ERR_MASK = 12'h858;
  localparam logic [REG_AW-1:0] OFF_ADDR     = 12'h880;

  // field positions
  localparam int SEL_BIT    = 16;
  localparam int BW_LSB     = 4;
  localparam int INC_BIT    = 0;
  localparam int GO_BIT     = 0;
  localparam int CHRST_LSB  = 8;
  localparam int FLAG_LSB   = 16;
  localparam int ALIGN_BITS = 7;
  localparam int NCH        = 2;

  typedef enum logic [2:0] {
    MV_IDLE, MV_MRD, MV_TXO, MV_RXI, MV_MWR, MV_DONE
  } mv_state_e;

  function automatic logic start_aligned(input logic [ALIGN_BITS-1:0] low);
    return low == '0;
  endfunction

  function automatic logic [63:0] step_addr(input logic [63:0] a, input logic inc,
                                            input logic [63:0] stride);
    return inc ? a + stride : a;
  endfunction

  function automatic logic [NCH-1:0] ch_flag(input logic ch);
    return ch ? 2'b10 : 2'b01;
  endfunction

  function automatic logic any_unmasked(input logic [NCH-1:0] flags, input logic [NCH-1:0] mask);
    return |(flags & ~mask);
  endfunction
endpackage

// File: rtl/sdma_regs.sv
module sdma_regs
  import sdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [63:0]       wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [63:0]       rd_data,
  input  logic [NCH-1:0]    done_set,
  input  logic [NCH-1:0]    err_set,
  output logic              sel_ch,
  output logic              inc_en,
  output logic [63:0]       xfer_addr,
  output logic              go_pulse,
  output logic [NCH-1:0]    chan_run,
  output logic [NCH-1:0]    end_flags,
  output logic [NCH-1:0]    err_flags,
  output logic [NCH-1:0]    end_mask,
  output logic [NCH-1:0]    err_mask
);
  logic            sel_q, inc_q;
  logic [1:0]      bw_q;
  logic [63:0]     addr_q;
  logic [NCH-1:0]  run_q, end_q, err_q, end_nx, err_nx;
  logic [31:0]     endm_q, errm_q;

  always_comb begin
    end_nx = end_q;
    err_nx = err_q;
    if (wr_en && wr_addr == OFF_END) end_nx = end_q & wr_data[FLAG_LSB +: NCH];
    if (wr_en && wr_addr == OFF_ERR) err_nx = err_q & wr_data[FLAG_LSB +: NCH];
    end_nx = (end_nx | done_set) & run_q;
    err_nx = (err_nx | err_set) & run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      inc_q  <= 1'b0;
      bw_q   <= 2'b00;
      addr_q <= '0;
      run_q  <= '1;
      end_q  <= '0;
      err_q  <= '0;
      endm_q <= '1;
      errm_q <= '1;
    end else begin
      end_q <= end_nx;
      err_q <= err_nx;
      if (wr_en) begin
        unique case (wr_addr)
          OFF_MODE: begin
            sel_q <= wr_data[SEL_BIT];
            bw_q  <= wr_data[BW_LSB +: 2];
            inc_q <= wr_data[INC_BIT];
          end
          OFF_RST:      run_q  <= wr_data[CHRST_LSB +: NCH];
          OFF_END_MASK: endm_q <= wr_data[31:0];
          OFF_ERR_MASK: errm_q <= wr_data[31:0];
          OFF_ADDR:     addr_q <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      OFF_MODE: begin
        rd_data[SEL_BIT]       = sel_q;
        rd_data[BW_LSB +: 2]   = bw_q;
        rd_data[INC_BIT]       = inc_q;
      end
      OFF_RST:      rd_data[31:0] = '1;
      OFF_END:      rd_data[FLAG_LSB +: NCH] = end_q;
      OFF_ERR:      rd_data[FLAG_LSB +: NCH] = err_q;
      OFF_END_MASK: rd_data[31:0] = endm_q;
      OFF_ERR_MASK: rd_data[31:0] = errm_q;
      OFF_ADDR:     rd_data = addr_q;
      default: ;
    endcase
  end

  assign go_pulse  = wr_en && (wr_addr == OFF_CTRL) && wr_data[GO_BIT];
  assign sel_ch    = sel_q;
  assign inc_en    = inc_q;
  assign xfer_addr = addr_q;
  assign chan_run  = run_q;
  assign end_flags = end_q;
  assign err_flags = err_q;
  assign end_mask  = endm_q[FLAG_LSB +: NCH];
  assign err_mask  = errm_q[FLAG_LSB +: NCH];
endmodule

// File: rtl/sdma_mover.sv
module sdma_mover
  import sdma_pkg::*;
#(
  parameter int DW = 64,
  parameter int CW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           start_ch,
  input  logic           start_inc,
  input  logic [63:0]    start_addr,
  input  logic [CW-1:0]  start_count,
  input  logic [NCH-1:0] chan_run,
  output logic           mem_req,
  output logic           mem_we,
  output logic [63:0]    mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_ack,
  input  logic [DW-1:0]  mem_rdata,
  output logic           tx_valid,
  output logic [DW-1:0]  tx_data,
  input  logic           tx_ready,
  input  logic           rx_valid,
  input  logic [DW-1:0]  rx_data,
  output logic           rx_ready,
  output logic           busy,
  output logic           act_ch,
  output logic           done
);
  localparam logic [63:0] STRIDE = 64'(DW / 8);

  mv_state_e      state;
  logic           ch_q, inc_q;
  logic [63:0]    addr_q;
  logic [CW-1:0]  left_q;
  logic [DW-1:0]  data_q;
  logic           abort, last_beat;

  assign abort     = (state != MV_IDLE) && !chan_run[ch_q];
  assign last_beat = (left_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= MV_IDLE;
      ch_q   <= 1'b0;
      inc_q  <= 1'b0;
      addr_q <= '0;
      left_q <= '0;
      data_q <= '0;
    end else if (abort) begin
      state <= MV_IDLE;
    end else begin
      unique case (state)
        MV_IDLE: if (start) begin
          ch_q   <= start_ch;
          inc_q  <= start_inc;
          addr_q <= start_addr;
          left_q <= start_count;
          if (start_count == '0) state <= MV_DONE;
          else                   state <= start_ch ? MV_RXI : MV_MRD;
        end
        MV_MRD: if (mem_ack) begin
          data_q <= mem_rdata;
          state  <= MV_TXO;
        end
        MV_TXO: if (tx_ready) begin
          addr_q <= step_addr(addr_q, inc_q, STRIDE);
          left_q <= left_q - CW'(1);
          state  <= last_beat ? MV_DONE : MV_MRD;
        end
        MV_RXI: if (rx_valid) begin
          data_q <= rx_data;
          state  <= MV_MWR;
        end
        MV_MWR: if (mem_ack) begin
          addr_q <= step_addr(addr_q, inc_q, STRIDE);
          left_q <= left_q - CW'(1);
          state  <= last_beat ? MV_DONE : MV_RXI;
        end
        MV_DONE: state <= MV_IDLE;
        default: state <= MV_IDLE;
      endcase
    end
  end

  assign mem_req   = (state == MV_MRD) || (state == MV_MWR);
  assign mem_we    = (state == MV_MWR);
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;
  assign tx_valid  = (state == MV_TXO);
  assign tx_data   = data_q;
  assign rx_ready  = (state == MV_RXI);
  assign busy      = (state != MV_IDLE);
  assign act_ch    = ch_q;
  assign done      = (state == MV_DONE) && !abort;
endmodule

// File: rtl/sdcard_dma.sv
module sdcard_dma
  import sdma_pkg::*;
#(
  parameter int DW = 64,
  parameter int CW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_waddr,
  input  logic [63:0]       cfg_wdata,
  input  logic [REG_AW-1:0] cfg_raddr,
  output logic [63:0]       cfg_rdata,
  input  logic [CW-1:0]     xfer_count,
  output logic              mem_req,
  output logic              mem_we,
  output logic [63:0]       mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_ack,
  input  logic [DW-1:0]     mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DW-1:0]     tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DW-1:0]     rx_data,
  output logic              irq
);
  logic           sel_ch, inc_en, go_pulse;
  logic [63:0]    xfer_addr;
  logic [NCH-1:0] chan_run, end_flags, err_flags, end_mask, err_mask;
  logic [NCH-1:0] done_set, err_set;
  logic           mv_busy, act_ch, mv_done;
  logic           go_ok, aligned, mv_start, bad_start;

  sdma_regs u_regs (
    .clk, .rst_n,
    .wr_en(cfg_we), .wr_addr(cfg_waddr), .wr_data(cfg_wdata),
    .rd_addr(cfg_raddr), .rd_data(cfg_rdata),
    .done_set, .err_set,
    .sel_ch, .inc_en, .xfer_addr, .go_pulse, .chan_run,
    .end_flags, .err_flags, .end_mask, .err_mask
  );

  assign go_ok     = go_pulse && !mv_busy && chan_run[sel_ch];
  assign aligned   = start_aligned(xfer_addr[ALIGN_BITS-1:0]);
  assign mv_start  = go_ok && aligned;
  assign bad_start = go_ok && !aligned;
  assign err_set   = bad_start ? ch_flag(sel_ch) : '0;
  assign done_set  = mv_done ? ch_flag(act_ch) : '0;
  assign irq       = any_unmasked(end_flags, end_mask) | any_unmasked(err_flags, err_mask);

  sdma_mover #(.DW(DW), .CW(CW)) u_mover (
    .clk, .rst_n,
    .start(mv_start), .start_ch(sel_ch), .start_inc(inc_en),
    .start_addr(xfer_addr), .start_count(xfer_count), .chan_run,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata,
    .tx_valid, .tx_data, .tx_ready,
    .rx_valid, .rx_data, .rx_ready,
    .busy(mv_busy), .act_ch, .done(mv_done)
  );
endmodule

// File: rtl/sdma_checker.sv
module sdma_checker #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_we,
  input logic [63:0]   mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          tx_valid,
  input logic          rx_ready,
  input logic          busy,
  input logic          act_ch,
  input logic          sel_ch,
  input logic [1:0]    chan_run,
  input logic          done_evt,
  input logic          bad_start,
  input logic [1:0]    end_flags,
  input logic [1:0]    err_flags,
  input logic [1:0]    end_mask,
  input logic [1:0]    err_mask,
  input logic          irq
);
  logic abort_now;
  assign abort_now = busy && !chan_run[act_ch];

  assert_req_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !abort_now) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_single_handshake_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req, tx_valid, rx_ready}));

  assert_direction_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_we == act_ch));

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !tx_valid && !rx_ready));

  assert_bad_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bad_start |=> (!busy && !mem_req && err_flags[$past(sel_ch)]));

  assert_end_flag0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !act_ch) |=> (end_flags[0] || !chan_run[0]));

  assert_end_flag1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && act_ch) |=> (end_flags[1] || !chan_run[1]));

  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((&end_mask) && (&err_mask)) |-> !irq);

  assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_now |=> !busy);
endmodule

bind sdcard_dma sdma_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .tx_valid(tx_valid), .rx_ready(rx_ready),
  .busy(mv_busy), .act_ch(act_ch), .sel_ch(sel_ch), .chan_run(chan_run),
  .done_evt(mv_done), .bad_start(bad_start),
  .end_flags(end_flags), .err_flags(err_flags),
  .end_mask(end_mask), .err_mask(err_mask), .irq(irq)
);

// File: tb/sdcard_dma_bench.sv
module sdcard_dma_bench;
  import sdma_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              cfg_we;
  logic [REG_AW-1:0] cfg_waddr, cfg_raddr;
  logic [63:0]       cfg_wdata, cfg_rdata;
  logic [31:0]       xfer_count;
  logic              mem_req, mem_we, mem_ack;
  logic [63:0]       mem_addr, mem_wdata, mem_rdata;
  logic              tx_valid, tx_ready, rx_valid, rx_ready, irq;
  logic [63:0]       tx_data, rx_data;

  sdcard_dma u_sdcard_dma (
    .clk, .rst_n, .cfg_we, .cfg_waddr, .cfg_wdata, .cfg_raddr, .cfg_rdata,
    .xfer_count, .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata,
    .tx_valid, .tx_ready, .tx_data, .rx_valid, .rx_ready, .rx_data, .irq
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic        exp_ch, exp_inc;
  logic [63:0] exp_base;
  int exp_n = 0, mem_k = 0, tx_idx = 0, rx_idx = 0, last_c = -100;
  int mem_total = 0, wait_n = 0;

  function automatic logic [63:0] mem_pat(input logic [63:0] a);
    return {a[31:0] ^ 32'hA5A5_5A5A, a[31:0]};
  endfunction
  function automatic logic [63:0] rx_pat(input int k);
    return {32'hC0DE_0000 + k[31:0], ~k[31:0]};
  endfunction
  function automatic logic [63:0] exp_addr(input int k);
    return exp_base + (exp_inc ? 64'(k) * 64'd8 : 64'd0);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [REG_AW-1:0] a, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [REG_AW-1:0] a, output logic [63:0] d);
    cfg_raddr = a;
    #1;
    d = cfg_rdata;
  endtask

  // memory model
  initial begin
    mem_ack = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (wait_n > 0) begin
          wait_n--;
          chk("R12 request held", mem_addr, exp_addr(mem_k));
        end else begin
          mem_ack = 1'b1;
          mem_rdata = mem_pat(mem_addr);
          chk("R4 beat address", mem_addr, exp_addr(mem_k));
          chk("R3 direction", 64'(mem_we), 64'(exp_ch));
          if (mem_we) begin
            chk("R3 memory write data", mem_wdata, rx_pat(mem_k));
            if (mem_k == exp_n - 1) last_c = cyc;
          end
          mem_k++;
          mem_total++;
          wait_n = mem_total % 3;
        end
      end
    end
  end

  // card FIFO sink (memory to card)
  initial begin
    tx_ready = 1'b0;
    forever begin
      @(negedge clk);
      tx_ready = (cyc % 3) != 1;
      if (tx_valid && tx_ready) begin
        chk("R2 card word", tx_data, mem_pat(exp_addr(tx_idx)));
        if (tx_idx == exp_n - 1) last_c = cyc;
        tx_idx++;
      end
    end
  end

  // card FIFO source (card to memory)
  initial begin
    rx_valid = 1'b0; rx_data = '0;
    forever begin
      @(negedge clk);
      rx_valid = (cyc % 4) != 2;
      rx_data = rx_pat(rx_idx);
      if (rx_valid && rx_ready) rx_idx++;
    end
  end

  task automatic arm(input logic ch, input logic inc, input logic [63:0] base, input int n);
    exp_ch = ch; exp_inc = inc; exp_base = base; exp_n = n;
    mem_k = 0; tx_idx = 0; rx_idx = 0; last_c = -100;
    reg_write(OFF_MODE, (64'(ch) << SEL_BIT) | 64'h30 | 64'(inc));
    reg_write(OFF_ADDR, base);
    xfer_count = 32'(n);
  endtask

  task automatic run_xfer(input logic ch, input logic inc, input logic [63:0] base,
                          input int n, input bit disturb, input bit keep);
    logic [63:0] v;
    int seen;
    int start_c;
    arm(ch, inc, base, n);
    reg_write(OFF_CTRL, 64'h1);
    start_c = cyc - 1;
    if (n == 0) last_c = start_c;
    if (disturb) begin
      repeat (2) @(negedge clk);
      reg_write(OFF_MODE, (64'(~ch) << SEL_BIT) | 64'(~inc));
      reg_write(OFF_CTRL, 64'h1);
    end
    seen = -1;
    for (int i = 0; i < 400 && seen < 0; i++) begin
      reg_read(OFF_END, v);
      if (v[FLAG_LSB + int'(ch)]) seen = cyc;
      else @(negedge clk);
    end
    if (n == 0) chk("R11 zero-count end timing", 64'(seen), 64'(last_c + 2));
    else        chk("R7 end flag cycle", 64'(seen), 64'(last_c + 2));
    chk("R4 memory beats", 64'(mem_k), 64'(n));
    if (ch) chk("R3 card words taken", 64'(rx_idx), 64'(n));
    else    chk("R2 card words given", 64'(tx_idx), 64'(n));
    if (!keep) begin
      reg_write(OFF_END, 64'h0);
      reg_read(OFF_END, v);
      chk("R8 clear by zero", v, 64'h0);
    end
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [63:0] v;
    int snap;
    cfg_we = 1'b0; cfg_waddr = '0; cfg_wdata = '0; cfg_raddr = '0; xfer_count = '0;
    exp_ch = 1'b0; exp_inc = 1'b0; exp_base = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    reg_read(OFF_MODE, v);     chk("R1 mode reset", v, 64'h0);
    reg_read(OFF_CTRL, v);     chk("R1 ctrl reset", v, 64'h0);
    reg_read(OFF_RST, v);      chk("R1 chan reset readback", v, 64'hFFFF_FFFF);
    reg_read(OFF_END, v);      chk("R1 end flags", v, 64'h0);
    reg_read(OFF_ERR, v);      chk("R1 err flags", v, 64'h0);
    reg_read(OFF_END_MASK, v); chk("R1 end mask", v, 64'hFFFF_FFFF);
    reg_read(OFF_ERR_MASK, v); chk("R1 err mask", v, 64'hFFFF_FFFF);
    reg_read(OFF_ADDR, v);     chk("R1 addr reset", v, 64'h0);
    chk("R1 irq low", 64'(irq), 64'h0);
    chk("R1 idle handshakes", 64'({mem_req, tx_valid, rx_ready}), 64'h0);

    // R2: mode readback keeps only its fields
    reg_write(OFF_MODE, '1);
    reg_read(OFF_MODE, v);     chk("R2 mode fields", v, 64'h0001_0031);
    reg_write(OFF_CTRL, '0);
    reg_read(OFF_CTRL, v);     chk("R5 ctrl reads zero", v, 64'h0);

    // sweep: channel x increment x length
    for (int c = 0; c < 2; c++)
      for (int m = 0; m < 2; m++)
        for (int li = 0; li < 5; li++) begin
          int n;
          n = (li == 4) ? 7 : li;
          run_xfer(c[0], m[0], 64'h0000_0004_0000_1000 + 64'((c * 2 + m) * 128), n, 1'b0, 1'b0);
        end

    // R5: start and mode writes while busy leave the transfer intact
    run_xfer(1'b0, 1'b1, 64'h0000_0000_0008_0000, 8, 1'b1, 1'b0);
    run_xfer(1'b1, 1'b1, 64'h0000_0000_0009_0000, 8, 1'b1, 1'b0);

    // R8 / R9: masks and partial clear
    run_xfer(1'b0, 1'b1, 64'h2000, 2, 1'b0, 1'b1);
    chk("R9 masked flag keeps irq low", 64'(irq), 64'h0);
    reg_write(OFF_END_MASK, 64'hFFFE_FFFF);
    chk("R9 unmasked end raises irq", 64'(irq), 64'h1);
    run_xfer(1'b1, 1'b0, 64'h2080, 3, 1'b0, 1'b1);
    reg_read(OFF_END, v);      chk("R7 both end flags", v, 64'h3_0000);
    reg_write(OFF_END, 64'h1_0000);
    reg_read(OFF_END, v);      chk("R8 partial clear", v, 64'h1_0000);
    chk("R9 irq with ch0 unmasked", 64'(irq), 64'h1);
    reg_write(OFF_END, 64'h1_0000);
    reg_read(OFF_END, v);      chk("R8 write of one keeps flag", v, 64'h1_0000);
    reg_write(OFF_END, 64'h0);
    chk("R9 irq drops after clear", 64'(irq), 64'h0);
    reg_write(OFF_END_MASK, 64'hFFFF_FFFF);

    // R6: misaligned starts on both channels
    for (int c = 0; c < 2; c++) begin
      snap = mem_total;
      arm(c[0], 1'b1, (c == 0) ? 64'h3040 : 64'h3008, 4);
      reg_write(OFF_ERR_MASK, 64'h0);
      reg_write(OFF_CTRL, 64'h1);
      reg_read(OFF_ERR, v);    chk("R6 error flag", v, 64'h1_0000 << c);
      reg_read(OFF_END, v);    chk("R6 no end flag", v, 64'h0);
      chk("R9 unmasked error raises irq", 64'(irq), 64'h1);
      repeat (8) @(negedge clk);
      chk("R6 no memory traffic", 64'(mem_total - snap), 64'h0);
      chk("R6 no card traffic", 64'(tx_idx + rx_idx), 64'h0);
      reg_write(OFF_ERR, 64'h0);
      reg_read(OFF_ERR, v);    chk("R8 error cleared", v, 64'h0);
      reg_write(OFF_ERR_MASK, 64'hFFFF_FFFF);
    end

    // R10: channel 0 reset aborts and blocks it, channel 1 keeps working
    arm(1'b0, 1'b1, 64'h4000, 40);
    reg_write(OFF_CTRL, 64'h1);
    repeat (10) @(negedge clk);
    reg_write(OFF_RST, 64'h200);
    @(negedge clk);
    chk("R10 abort drops handshakes", 64'({mem_req, tx_valid}), 64'h0);
    snap = mem_total;
    repeat (10) @(negedge clk);
    chk("R10 no traffic after abort", 64'(mem_total - snap), 64'h0);
    reg_read(OFF_END, v);      chk("R10 no end flag on abort", v, 64'h0);
    reg_read(OFF_RST, v);      chk("R10 reset readback ones", v, 64'hFFFF_FFFF);
    reg_write(OFF_CTRL, 64'h1);
    repeat (5) @(negedge clk);
    chk("R10 start ignored in reset", 64'(mem_total - snap), 64'h0);
    reg_read(OFF_ERR, v);      chk("R10 no error in reset", v, 64'h0);
    run_xfer(1'b1, 1'b1, 64'h5000, 3, 1'b0, 1'b0);
    reg_write(OFF_RST, 64'h300);
    run_xfer(1'b0, 1'b1, 64'h6000, 3, 1'b0, 1'b0);

    finish_run();
  end
endmodule